// File: doc/BRIEF.md
# External Parallel Memory Access Sequencer

This block runs one read or one write at a time against an external parallel ROM or flash part. The part has a 24-bit word address and a 16-bit data bus. A requester presents a direction bit, an address and, for writes, a data word, and holds a valid strobe. The sequencer takes the request in a clock where it is idle. It then drives the active-low chip select, output enable and write enable in a fixed pattern counted in core clocks. At the end it raises a one-clock acknowledge, which for reads comes with the captured data word.

Every access keeps chip select low for six clocks. A read lowers output enable two clocks after chip select and holds it for three clocks, and the data is sampled on the last of those clocks. A write lowers write enable one clock after chip select and holds it for four clocks. The data bus is driven from the start of the write to one clock past the rise of write enable. The data bus driver is off in every other cycle. A power-down input gates all strobes high, releases both the address bus and the data bus, and returns the sequencer to idle.

Top module: `mseq_top`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0 and req_ack is 0.
- R2: A read accepted at a clock edge keeps mem_cs_n low for exactly 6 consecutive cycles, starting in the cycle after that edge, with mem_addr equal to the requested address during all 6.
- R3: In a read, mem_oe_n falls in the 3rd chip-select-low cycle (index 2, counting from 0) and stays low for exactly 3 cycles. mem_we_n stays 1.
- R4: A read returns the value on mem_dq_in at the clock edge that ends the last output-enable-low cycle. That value is shown on rsp_rdata in the acknowledge cycle.
- R5: A write keeps mem_cs_n low for exactly 6 cycles. mem_we_n falls in chip-select-low cycle index 1 and stays low for exactly 4 cycles. mem_oe_n stays 1.
- R6: In a write, mem_dq_oe is 1 and mem_dq_out equals the requested data in all 6 chip-select-low cycles. The data is therefore set up 5 cycles before mem_we_n rises and is held 1 cycle after.
- R7: mem_oe_n and mem_we_n are never both low. mem_dq_oe is never 1 outside a write, or while mem_oe_n is low.
- R8: Address and chip select stay stable for a whole access. A request held valid during an access is not started until the cycle after the acknowledge. Changes to req_addr after acceptance do not affect the running access.
- R9: While pwr_down is 1, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_addr_oe and mem_dq_oe are 0, and req_ack is 0. An access in flight is dropped, and requests are not accepted.
- R10: req_ack is a single-cycle pulse in the last chip-select-low cycle. Back-to-back accesses are separated by exactly one cycle with mem_cs_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_down | input | 1 | Power-down: strobes inactive, buses released |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address of the request |
| req_wdata | input | 16 | Write data of the request |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with req_ack of a read |
| mem_addr | output | 24 | External word address |
| mem_addr_oe | output | 1 | Address bus driver enable |
| mem_cs_n | output | 1 | External chip select, active low |
| mem_oe_n | output | 1 | External output enable, active low |
| mem_we_n | output | 1 | External write enable, active low |
| mem_dq_out | output | 16 | Data driven to the external bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 16 | Data read from the external bus |

## Verification
With the request applied before edge E0, chip select is low from the cycle after E0. Output enable or write enable follows at a fixed index into that window (2 for reads, 1 for writes), and the acknowledge with its read data lands at index 5. The bench drives inputs on falling edges and records every pin once per cycle, also on the falling edge. Index 0 of the record is the first falling edge after acceptance, so each check compares a trace position against the cycle count stated in its requirement. The external memory model returns valid data only in the third output-enable cycle, so a capture at any other edge shows up as a wrong read value.

// File: rtl/mseq_pkg.sv
// Shared types of the memory access sequencer.
package mseq_pkg;
    // Phase of one external access; IDLE means chip select is inactive.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_STROBE,
        PH_TAIL
    } phase_t;
endpackage

// File: rtl/mseq_timer.sv
// Phase timer: walks one access through lead, strobe and tail phases,
// each lasting a parameter number of core clocks chosen by direction.
// Assumes every length parameter is at least 1.
module mseq_timer
    import mseq_pkg::*;
#(
    parameter int RD_LEAD  = 2,
    parameter int RD_PULSE = 3,
    parameter int WR_LEAD  = 1,
    parameter int WR_PULSE = 4,
    parameter int TAIL_LEN = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pwr_down,
    input  logic   req_valid,
    input  logic   req_write,
    output phase_t phase,
    output logic   is_write,
    output logic   accept,
    output logic   capture
);
    localparam int MAX_A  = (RD_LEAD > WR_LEAD) ? RD_LEAD : WR_LEAD;
    localparam int MAX_B  = (RD_PULSE > WR_PULSE) ? RD_PULSE : WR_PULSE;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXLEN = (MAX_C > TAIL_LEN) ? MAX_C : TAIL_LEN;
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lead_last;
    logic [CNT_W-1:0] pulse_last;
    logic [CNT_W-1:0] tail_last;

    // Last count value of each phase for the current direction.
    always_comb begin
        lead_last  = is_write ? CNT_W'(WR_LEAD - 1)  : CNT_W'(RD_LEAD - 1);
        pulse_last = is_write ? CNT_W'(WR_PULSE - 1) : CNT_W'(RD_PULSE - 1);
        tail_last  = CNT_W'(TAIL_LEN - 1);
    end

    // Request acceptance and read-capture strobe.
    always_comb begin
        accept  = (phase == PH_IDLE) && req_valid && !pwr_down;
        capture = (phase == PH_STROBE) && (cnt == pulse_last) && !is_write && !pwr_down;
    end

    // Phase and counter sequencing; power-down drops the access.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            is_write <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase    <= PH_LEAD;
                        is_write <= req_write;
                        cnt      <= '0;
                    end
                end
                PH_LEAD: begin
                    if (cnt == lead_last) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt == pulse_last) begin
                        phase <= PH_TAIL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == tail_last) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mseq_datapath.sv
// Datapath: holds the accepted address and write data for the whole
// access and captures the read word on the timer's capture strobe.
module mseq_datapath #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    // Request registers, loaded only when a new access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Read word, sampled at the end of the output-enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= dq_in;
        end
    end
endmodule

// File: rtl/mseq_pads.sv
// Pin decode: turns the phase into active-low strobes and bus enables.
// Power-down overrides every pin combinationally.
module mseq_pads
    import mseq_pkg::*;
(
    input  phase_t phase,
    input  logic   is_write,
    input  logic   pwr_down,
    output logic   cs_n,
    output logic   oe_n,
    output logic   we_n,
    output logic   addr_oe,
    output logic   dq_oe,
    output logic   ack
);
    logic active;
    logic strobe;

    // Strobe, enable and acknowledge decode.
    always_comb begin
        active  = (phase != PH_IDLE) && !pwr_down;
        strobe  = active && (phase == PH_STROBE);
        cs_n    = !active;
        oe_n    = !(strobe && !is_write);
        we_n    = !(strobe && is_write);
        addr_oe = !pwr_down;
        dq_oe   = active && is_write;
        ack     = active && (phase == PH_TAIL);
    end
endmodule

// File: rtl/mseq_top.sv
// External ROM/flash access sequencer, top level. Accepts one request at
// a time through a valid/acknowledge port and runs a fixed-length bus
// cycle. Assumes the requester keeps req_valid high until it is accepted.
module mseq_top
    import mseq_pkg::*;
#(
    parameter int AW       = 24,
    parameter int DW       = 16,
    parameter int RD_LEAD  = 2,
    parameter int RD_PULSE = 3,
    parameter int WR_LEAD  = 1,
    parameter int WR_PULSE = 4,
    parameter int TAIL_LEN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_addr_oe,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    phase_t phase;
    logic   is_write;
    logic   accept;
    logic   capture;

    mseq_timer #(
        .RD_LEAD (RD_LEAD),
        .RD_PULSE(RD_PULSE),
        .WR_LEAD (WR_LEAD),
        .WR_PULSE(WR_PULSE),
        .TAIL_LEN(TAIL_LEN)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .req_valid(req_valid),
        .req_write(req_write),
        .phase    (phase),
        .is_write (is_write),
        .accept   (accept),
        .capture  (capture)
    );

    mseq_datapath #(
        .AW(AW),
        .DW(DW)
    ) dp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .dq_in    (mem_dq_in),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out),
        .rdata_q  (rsp_rdata)
    );

    mseq_pads pads_i (
        .phase   (phase),
        .is_write(is_write),
        .pwr_down(pwr_down),
        .cs_n    (mem_cs_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n),
        .addr_oe (mem_addr_oe),
        .dq_oe   (mem_dq_oe),
        .ack     (req_ack)
    );
endmodule

// File: rtl/mseq_chk.sv
// Protocol checker for mseq_top, attached by bind. Tracks how long each
// strobe has been low with small saturating counters.
module mseq_chk #(
    parameter int AW       = 24,
    parameter int RD_LEAD  = 2,
    parameter int RD_PULSE = 3,
    parameter int WR_LEAD  = 1,
    parameter int WR_PULSE = 4,
    parameter int TAIL_LEN = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_down,
    input logic          req_ack,
    input logic [AW-1:0] mem_addr,
    input logic          mem_addr_oe,
    input logic          mem_cs_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);
    localparam int RD_TOTAL = RD_LEAD + RD_PULSE + TAIL_LEN;
    localparam int WR_TOTAL = WR_LEAD + WR_PULSE + TAIL_LEN;

    logic [3:0] cs_run, oe_run, we_run, dq_run;

    // Run-length counters of low strobes and data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_run <= '0; oe_run <= '0; we_run <= '0; dq_run <= '0;
        end else begin
            cs_run <= mem_cs_n ? 4'd0 : (cs_run == 4'hF ? cs_run : cs_run + 4'd1);
            oe_run <= mem_oe_n ? 4'd0 : (oe_run == 4'hF ? oe_run : oe_run + 4'd1);
            we_run <= mem_we_n ? 4'd0 : (we_run == 4'hF ? we_run : we_run + 4'd1);
            dq_run <= !mem_dq_oe ? 4'd0 : (dq_run == 4'hF ? dq_run : dq_run + 4'd1);
        end
    end

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    p_dq_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_cs_n));
    p_pdown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_addr_oe && !mem_dq_oe && !req_ack));
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));
    p_oe_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (cs_run == 4'(RD_LEAD)));
    p_oe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_oe_n) && !pwr_down) |-> (oe_run == 4'(RD_PULSE)));
    p_we_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (cs_run == 4'(WR_LEAD)));
    p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !pwr_down) |-> (we_run == 4'(WR_PULSE)));
    p_wdata_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !pwr_down) |-> (mem_dq_oe && dq_run >= 4'(WR_PULSE)));
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
    p_ack_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (cs_run == 4'(RD_TOTAL - 1) || cs_run == 4'(WR_TOTAL - 1)));
endmodule

bind mseq_top mseq_chk #(
    .AW      (AW),
    .RD_LEAD (RD_LEAD),
    .RD_PULSE(RD_PULSE),
    .WR_LEAD (WR_LEAD),
    .WR_PULSE(WR_PULSE),
    .TAIL_LEN(TAIL_LEN)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .req_ack    (req_ack),
    .mem_addr   (mem_addr),
    .mem_addr_oe(mem_addr_oe),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/mseq_top_tb_top.sv
// Directed bench: records every pin once per cycle on the falling edge
// and compares trace positions against the required cycle counts.
module mseq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic [23:0] mem_addr;
    logic        mem_addr_oe, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_addr_oe(mem_addr_oe),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [15:0] model(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h3C5A;
    endfunction

    // Memory model: valid data only in the third output-enable cycle.
    logic [3:0] tb_oe_run = '0;
    always @(posedge clk) tb_oe_run <= mem_oe_n ? 4'd0 : tb_oe_run + 4'd1;
    assign mem_dq_in = (!mem_cs_n && !mem_oe_n && tb_oe_run == 4'd2) ? model(mem_addr) : 16'hBAD0;

    logic        t_cs [NT], t_oe [NT], t_we [NT], t_dq [NT], t_ack [NT];
    logic [23:0] t_addr [NT];
    logic [15:0] t_wd [NT], t_rd [NT];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Records n cycles; index 0 is the first cycle after acceptance.
    task automatic record(input int n, input int drop_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            t_cs[i] = mem_cs_n; t_oe[i] = mem_oe_n; t_we[i] = mem_we_n;
            t_dq[i] = mem_dq_oe; t_ack[i] = req_ack; t_addr[i] = mem_addr;
            t_wd[i] = mem_dq_out; t_rd[i] = rsp_rdata;
            if (i == drop_at) req_valid = 1'b0;
        end
    endtask

    task automatic start(input bit wr, input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack, "R1 during reset",
              {27'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ack}, 32'h1C);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack, "R1 after reset",
              {27'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ack}, 32'h1C);
    endtask

    task automatic test_read(input logic [23:0] a);
        int n_cs = 0, n_oe = 0, f_oe = -1, n_we = 0, n_dq = 0, n_ack = 0, bad_a = 0;
        start(0, a, 16'h0);
        record(10, 0);
        for (int i = 0; i < 10; i++) begin
            if (!t_cs[i]) begin n_cs++; if (t_addr[i] != a) bad_a++; end
            if (!t_oe[i]) begin n_oe++; if (f_oe < 0) f_oe = i; end
            if (!t_we[i]) n_we++;
            if (t_dq[i]) n_dq++;
            if (t_ack[i]) n_ack++;
        end
        check(n_cs == 6 && t_cs[0] == 0, "R2 read cs low cycles", n_cs, 6);
        check(bad_a == 0, "R2 read address held", bad_a, 0);
        check(f_oe == 2, "R3 oe start index", f_oe, 2);
        check(n_oe == 3, "R3 oe width", n_oe, 3);
        check(n_we == 0 && n_dq == 0, "R7 no write strobe or drive in read", n_we + n_dq, 0);
        check(t_ack[5] && n_ack == 1, "R10 read ack single at index 5", n_ack, 1);
        check(t_rd[5] == model(a), "R4 read data", t_rd[5], model(a));
    endtask

    task automatic test_write(input logic [23:0] a, input logic [15:0] d);
        int n_cs = 0, n_oe = 0, f_we = -1, n_we = 0, n_dq = 0, bad = 0;
        start(1, a, d);
        record(10, 0);
        for (int i = 0; i < 10; i++) begin
            if (!t_cs[i]) begin
                n_cs++;
                if (t_addr[i] != a || !t_dq[i] || t_wd[i] != d) bad++;
            end
            if (!t_oe[i]) n_oe++;
            if (!t_we[i]) begin n_we++; if (f_we < 0) f_we = i; end
            if (t_dq[i]) n_dq++;
        end
        check(n_cs == 6 && t_cs[0] == 0, "R5 write cs low cycles", n_cs, 6);
        check(f_we == 1 && n_we == 4, "R5 we index/width", {f_we[15:0], n_we[15:0]}, 32'h0001_0004);
        check(n_dq == 6 && bad == 0, "R6 write data driven whole cycle", {n_dq[15:0], bad[15:0]}, 32'h0006_0000);
        check(n_oe == 0, "R7 no oe in write", n_oe, 0);
        check(t_ack[5] && !t_ack[4] && !t_ack[6], "R10 write ack index", {29'd0, t_ack[4], t_ack[5], t_ack[6]}, 32'h2);
    endtask

    task automatic test_back_to_back(input logic [23:0] a, input logic [23:0] b);
        int bad = 0;
        start(0, a, 16'h0);
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            t_cs[i] = mem_cs_n; t_ack[i] = req_ack; t_addr[i] = mem_addr; t_rd[i] = rsp_rdata;
            if (i == 1) req_addr = b;
            if (i == 7) req_valid = 1'b0;
        end
        for (int i = 0; i < 6; i++) if (t_cs[i] || t_addr[i] != a) bad++;
        check(bad == 0, "R8 mid-cycle addr change ignored", bad, 0);
        check(t_cs[6] && !t_cs[7], "R10 one idle cycle between accesses", {30'd0, t_cs[6], t_cs[7]}, 32'h2);
        check(!t_ack[6] && t_ack[12], "R8 second access acked after first", {30'd0, t_ack[6], t_ack[12]}, 32'h1);
        check(t_addr[8] == b, "R8 second access address", t_addr[8], b);
        check(t_rd[5] == model(a) && t_rd[12] == model(b), "R4 back-to-back read data", t_rd[12], model(b));
    endtask

    task automatic test_power_down();
        int bad = 0;
        start(1, 24'h00_1234, 16'hC0DE);
        @(negedge clk); @(negedge clk);
        pwr_down = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!mem_cs_n || !mem_oe_n || !mem_we_n || mem_addr_oe || mem_dq_oe || req_ack) bad++;
        end
        check(bad == 0, "R9 pins quiet and requests ignored in power-down", bad, 0);
        req_valid = 1'b0;
        pwr_down = 1'b0;
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!mem_cs_n || req_ack || !mem_addr_oe) bad++;
        end
        check(bad == 0, "R9 aborted access does not resume", bad, 0);
        test_read(24'h00_0777);
    endtask

    initial begin
        test_reset();
        test_read(24'h12_3456);
        test_read(24'hFF_FFFF);
        test_write(24'h00_0000, 16'hA5C3);
        test_write(24'hAB_CDEF, 16'hFFFF);
        test_back_to_back(24'h00_1000, 24'h80_0001);
        test_power_down();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule